// File: doc/BRIEF.md
# Lockable GPIO Port

An eight-pin general-purpose I/O port with per-pin configuration held in small registers: pin direction, output level, output style (totem-pole or open-drain), pull enable and pull polarity. A sticky per-pin lock register freezes a pin's output level and every configuration bit of that pin once set. Only a reset clears the lock. The port drives the pad-side output enable, output value and the two pull controls. It reads the pad level back through a two-flop synchronizer.

Software-side access uses a plain register port: an address, a write strobe, write data and a per-pin write mask. Read data is combinational from the address. Each write affects only the pins selected by the mask and not protected by their lock bit. Reset is asserted asynchronously and released synchronously inside the block.

Top module: `gpio_lock_port`

## Requirements
- R1: After reset, every register at addresses 0 to 5 reads 0x00, and `pad_oe`, `pad_pu` and `pad_pd` are all 0.
- R2: Register address 0 holds direction (bit 1 = output, 0 = input) and address 1 holds output data. For a totem-pole pin, `pad_oe` equals its direction bit and `pad_out` equals its output data bit.
- R3: Register address 2 holds output type (bit 1 = open-drain, 0 = totem-pole). An open-drain output pin asserts `pad_oe` only while its output data bit is 0, and `pad_out` is then 0. An open-drain pin never drives `pad_out` high.
- R4: Register address 3 holds pull enable and address 4 holds pull polarity (0 = up, 1 = down). `pad_pu` is high only when the pin's enable is 1 and its polarity is 0. `pad_pd` is high only when the enable is 1 and the polarity is 1. Both are 0 whenever the enable is 0.
- R5: Address 6 returns the pad level of every pin, whatever its direction. A change on `pad_in` becomes readable after the second rising clock edge, and not after the first.
- R6: A write changes only the pins whose `reg_wmask` bit is 1. All other pins keep their stored value.
- R7: For a pin whose lock bit (address 5) is 1, writes to addresses 0 to 4 leave that pin's bit unchanged.
- R8: Writing to address 5 sets the lock bits that are selected by both the data and the mask. Writing zeros never clears a lock bit; only reset does.
- R9: Writes to address 6 have no effect. Address 7 reads 0x00 and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data, one bit per pin |
| reg_wmask | input | 8 | Per-pin write mask |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| pad_in | input | 8 | Pad input levels (asynchronous) |
| pad_oe | output | 8 | Pad output enable per pin |
| pad_out | output | 8 | Pad output value per pin |
| pad_pu | output | 8 | Pull-up enable per pin |
| pad_pd | output | 8 | Pull-down enable per pin |

## Verification
Some properties are checked by the assertions on every cycle. Locked pins keep their configuration and output bits. Lock bits never fall. Unmasked pins survive writes. An open-drain pin never drives high, pull-up and pull-down are never both on, and the readable input trails the pad by two edges. The bench scenarios must show the exact merged values after mixed masked and locked writes. They must also show the open-drain enable pattern against the output data, the missing value after a single edge, the ignored writes to the input and spare addresses, and that reset alone releases the locks.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_DIR   = 3'd0,
    RA_DOUT  = 3'd1,
    RA_OTYPE = 3'd2,
    RA_PEN   = 3'd3,
    RA_PDN   = 3'd4,
    RA_LOCK  = 3'd5,
    RA_DIN   = 3'd6,
    RA_SPARE = 3'd7
  } gpio_reg_e;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] din
);
  logic [W-1:0] meta_q, stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= pad_in;
      stab_q <= meta_q;
    end
  end

  assign din = stab_q;

  // settle counter used only by the latency check
  logic [1:0] settle_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 settle_q <= 2'd0;
    else if (settle_q != 2'd2)  settle_q <= settle_q + 2'd1;
  end

  assert_din_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (settle_q == 2'd2) |-> (din == $past(pad_in, 2)));
endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_port_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  input  logic [W-1:0]      wmask,
  output logic [W-1:0]      dir,
  output logic [W-1:0]      dout,
  output logic [W-1:0]      otype,
  output logic [W-1:0]      pen,
  output logic [W-1:0]      pdn,
  output logic [W-1:0]      lock
);
  logic [W-1:0] dir_q, dout_q, otype_q, pen_q, pdn_q, lock_q;
  logic [W-1:0] dir_d, dout_d, otype_d, pen_d, pdn_d, lock_d;
  logic [W-1:0] eff_mask;
  gpio_reg_e    sel;

  always_comb begin
    sel      = gpio_reg_e'(addr);
    eff_mask = wmask & ~lock_q;
    dir_d    = dir_q;
    dout_d   = dout_q;
    otype_d  = otype_q;
    pen_d    = pen_q;
    pdn_d    = pdn_q;
    lock_d   = lock_q;
    if (wr_en) begin
      unique case (sel)
        RA_DIR:   dir_d   = (dir_q   & ~eff_mask) | (wdata & eff_mask);
        RA_DOUT:  dout_d  = (dout_q  & ~eff_mask) | (wdata & eff_mask);
        RA_OTYPE: otype_d = (otype_q & ~eff_mask) | (wdata & eff_mask);
        RA_PEN:   pen_d   = (pen_q   & ~eff_mask) | (wdata & eff_mask);
        RA_PDN:   pdn_d   = (pdn_q   & ~eff_mask) | (wdata & eff_mask);
        RA_LOCK:  lock_d  = lock_q | (wdata & wmask);
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      dout_q  <= '0;
      otype_q <= '0;
      pen_q   <= '0;
      pdn_q   <= '0;
      lock_q  <= '0;
    end else if (wr_en) begin
      dir_q   <= dir_d;
      dout_q  <= dout_d;
      otype_q <= otype_d;
      pen_q   <= pen_d;
      pdn_q   <= pdn_d;
      lock_q  <= lock_d;
    end
  end

  assign dir   = dir_q;
  assign dout  = dout_q;
  assign otype = otype_q;
  assign pen   = pen_q;
  assign pdn   = pdn_q;
  assign lock  = lock_q;

  assert_lock_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(lock_q) & ~lock_q) == '0));

  assert_locked_dir_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((dir_q & $past(lock_q)) == ($past(dir_q) & $past(lock_q))));

  assert_locked_dout_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((dout_q & $past(lock_q)) == ($past(dout_q) & $past(lock_q))));

  assert_locked_pull_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((pen_q | pdn_q) & $past(lock_q)) ==
              (($past(pen_q) | $past(pdn_q)) & $past(lock_q))));

  assert_unmasked_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == RA_OTYPE) |=>
      ((otype_q & ~$past(wmask)) == ($past(otype_q) & ~$past(wmask))));
endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive #(
  parameter int W = 8
) (
  input  logic [W-1:0] dir,
  input  logic [W-1:0] dout,
  input  logic [W-1:0] otype,
  input  logic [W-1:0] pen,
  input  logic [W-1:0] pdn,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_pu,
  output logic [W-1:0] pad_pd
);
  for (genvar p = 0; p < W; p++) begin : g_pin
    always_comb begin
      if (otype[p]) begin
        pad_oe[p]  = dir[p] & ~dout[p];
        pad_out[p] = 1'b0;
      end else begin
        pad_oe[p]  = dir[p];
        pad_out[p] = dout[p];
      end
      pad_pu[p] = pen[p] & ~pdn[p];
      pad_pd[p] = pen[p] &  pdn[p];
    end
  end

  always_comb begin
    assert_od_never_high_R3: assert ((pad_out & pad_oe & otype) == '0);
    assert_pull_exclusive_R4: assert ((pad_pu & pad_pd) == '0);
  end
endmodule

// File: rtl/gpio_lock_port.sv
module gpio_lock_port
  import gpio_port_pkg::*;
#(
  parameter int PINS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [PINS-1:0]   reg_wdata,
  input  logic [PINS-1:0]   reg_wmask,
  output logic [PINS-1:0]   reg_rdata,
  input  logic [PINS-1:0]   pad_in,
  output logic [PINS-1:0]   pad_oe,
  output logic [PINS-1:0]   pad_out,
  output logic [PINS-1:0]   pad_pu,
  output logic [PINS-1:0]   pad_pd
);
  logic            rst_int_n;
  logic [PINS-1:0] dir, dout, otype, pen, pdn, lock, din;

  gpio_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  gpio_in_sync #(.W(PINS)) u_insync (
    .clk(clk), .rst_n(rst_int_n), .pad_in(pad_in), .din(din)
  );

  gpio_cfg_regs #(.W(PINS)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .wr_en(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .wmask(reg_wmask),
    .dir(dir), .dout(dout), .otype(otype), .pen(pen), .pdn(pdn), .lock(lock)
  );

  gpio_pad_drive #(.W(PINS)) u_drive (
    .dir(dir), .dout(dout), .otype(otype), .pen(pen), .pdn(pdn),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu), .pad_pd(pad_pd)
  );

  always_comb begin
    unique case (gpio_reg_e'(reg_addr))
      RA_DIR:   reg_rdata = dir;
      RA_DOUT:  reg_rdata = dout;
      RA_OTYPE: reg_rdata = otype;
      RA_PEN:   reg_rdata = pen;
      RA_PDN:   reg_rdata = pdn;
      RA_LOCK:  reg_rdata = lock;
      RA_DIN:   reg_rdata = din;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: tb/test_gpio_lock_port.sv
module test_gpio_lock_port;
  localparam int W = 8;
  localparam int SEL_RD = 0, SEL_OE = 1, SEL_OUT = 2, SEL_PU = 3, SEL_PD = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         reg_wr;
  logic [2:0]   reg_addr;
  logic [W-1:0] reg_wdata, reg_wmask, reg_rdata, pad_in;
  logic [W-1:0] pad_oe, pad_out, pad_pu, pad_pd;

  typedef struct {
    int         sel;
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t sb_q[$];
  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;

  always #10 clk = ~clk;

  gpio_lock_port i_gpio_lock_port (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_wmask(reg_wmask), .reg_rdata(reg_rdata),
    .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
    .pad_pu(pad_pu), .pad_pd(pad_pd)
  );

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      wait (sb_q.size() > 0);
      #1;
      begin
        item_t it;
        logic [7:0] act;
        it = sb_q.pop_front();
        case (it.sel)
          SEL_RD:  act = reg_rdata;
          SEL_OE:  act = pad_oe;
          SEL_OUT: act = pad_out;
          SEL_PU:  act = pad_pu;
          default: act = pad_pd;
        endcase
        n_cmp++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic push(int sel, logic [7:0] exp, string tag);
    item_t it;
    it.sel = sel; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    wait (sb_q.size() == 0);
  endtask

  task automatic rd(logic [2:0] a, logic [7:0] exp, string tag);
    @(negedge clk);
    reg_addr = a;
    push(SEL_RD, exp, tag);
  endtask

  task automatic pads(logic [7:0] oe, logic [7:0] o, logic [7:0] pu,
                      logic [7:0] pd, string tag);
    @(negedge clk);
    push(SEL_OE, oe, {tag, " oe"});
    push(SEL_OUT, o, {tag, " out"});
    push(SEL_PU, pu, {tag, " pu"});
    push(SEL_PD, pd, {tag, " pd"});
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d, logic [7:0] m);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_wmask = m;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; reg_wmask = '0; pad_in = '0;
    rst_n = 1'b1;
    do_reset();

    // R1 reset state
    for (int a = 0; a < 6; a++) rd(3'(a), 8'h00, "R1 reg after reset");
    pads(8'h00, 8'h00, 8'h00, 8'h00, "R1 pads after reset");

    // R6 masked write, R2 totem-pole drive
    wr(3'd0, 8'hFF, 8'h0F);
    rd(3'd0, 8'h0F, "R6 masked dir write");
    wr(3'd0, 8'h00, 8'h00);
    rd(3'd0, 8'h0F, "R6 zero mask keeps dir");
    wr(3'd1, 8'hA5, 8'hFF);
    rd(3'd1, 8'hA5, "R2 dout readback");
    pads(8'h0F, 8'hA5, 8'h00, 8'h00, "R2 push-pull");

    // R3 open-drain on pins 0,1
    wr(3'd2, 8'h03, 8'hFF);
    pads(8'h0E, 8'hA4, 8'h00, 8'h00, "R3 open-drain");

    // R4 pulls
    wr(3'd3, 8'hF0, 8'hFF);
    wr(3'd4, 8'hCC, 8'hFF);
    pads(8'h0E, 8'hA4, 8'h30, 8'hC0, "R4 pull select");

    // R5 input sync latency, independent of direction
    @(negedge clk);
    pad_in = 8'h3C;
    rd(3'd6, 8'h00, "R5 not visible after one edge");
    rd(3'd6, 8'h3C, "R5 visible after two edges");

    // R9 ignored writes
    wr(3'd6, 8'hFF, 8'hFF);
    rd(3'd6, 8'h3C, "R9 din write ignored");
    wr(3'd7, 8'hFF, 8'hFF);
    rd(3'd7, 8'h00, "R9 spare address");
    pads(8'h0E, 8'hA4, 8'h30, 8'hC0, "R9 pads unchanged");

    // R7 lock pins 0 and 7
    wr(3'd5, 8'h81, 8'hFF);
    rd(3'd5, 8'h81, "R7 lock set");
    wr(3'd0, 8'hFF, 8'hFF);
    wr(3'd1, 8'h00, 8'hFF);
    wr(3'd2, 8'hFF, 8'hFF);
    wr(3'd3, 8'h00, 8'hFF);
    wr(3'd4, 8'h00, 8'hFF);
    rd(3'd0, 8'h7F, "R7 dir locked pins");
    rd(3'd1, 8'h81, "R7 dout locked pins");
    rd(3'd2, 8'h7F, "R7 otype locked pins");
    rd(3'd3, 8'h80, "R7 pen locked pins");
    rd(3'd4, 8'h80, "R7 pdn locked pins");
    pads(8'h7E, 8'h80, 8'h00, 8'h80, "R7 pads after locked writes");

    // R8 lock sticky
    wr(3'd5, 8'h00, 8'hFF);
    rd(3'd5, 8'h81, "R8 zero write keeps lock");
    wr(3'd5, 8'h02, 8'h00);
    rd(3'd5, 8'h81, "R8 unmasked lock bit");
    wr(3'd5, 8'h02, 8'h02);
    rd(3'd5, 8'h83, "R8 lock add");
    do_reset();
    rd(3'd5, 8'h00, "R8 reset clears lock");
    rd(3'd0, 8'h00, "R1 dir after second reset");
    pads(8'h00, 8'h00, 8'h00, 8'h00, "R1 pads after second reset");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule